// File: doc/BRIEF.md
# Write-Through Accelerator Cache Controller

This block sits between a fast 8-bit processor core and a slow system bus with a 16-bit address. Every core cycle is a memory access. The block keeps a direct-mapped byte cache. Each entry is indexed by the low address bits and holds a byte and a small tag made of the upper address bits plus a valid bit.

A read whose tag matches is answered in the same fast cycle. All other accesses stall the core and run over the slow bus through a request/acknowledge handshake:

- read misses, which also fill the entry;
- every write, which is written through and also updates the entry;
- any access that falls in an excluded address window, which never touches the cache.

Excluded windows come from a small table of base/mask pairs. The block can change these pairs at run time through a configuration write port. Out of reset, the table holds one enabled window over the disk I/O slot range.

After reset the controller sweeps the whole tag store to clear the valid bits. It holds `busy` high until the sweep ends. Three counters report cache hits, read misses and completed slow-bus accesses.

Top module: `accel_cache_ctrl`

## Requirements
- R1: While reset is asserted, `busy` is 1, `cpu_ready` and `bus_req` are 0, and all three counters read 0.
- R2: After reset is released, `busy` stays high for exactly 2^IDX_W clock edges (8192 by default). While `busy` is high, no access completes and no bus request is raised.
- R3: A non-excluded read hits when the entry at index `addr[IDX_W-1:0]` is valid and its tag equals `addr[15:IDX_W]`. A hit returns the cached byte with `cpu_ready` high in the same cycle, and no bus request is made.
- R4: A non-excluded read miss raises `bus_req` with `bus_we`=0. It returns `bus_rdata` in the cycle `bus_ack` is seen and fills the entry, so the next read of that address hits.
- R5: Every write goes to the slow bus with `bus_we`=1 and the core's data. A write to a non-excluded address also stores the byte and tag in the cache, so a following read hits and returns the written byte.
- R6: Two addresses with the same index and different upper bits evict each other. Reading one after the other always misses.
- R7: An address is excluded when `(addr & mask) == base` for any enabled table entry. Excluded reads and writes always use the bus and never fill or update the cache.
- R8: After reset, entry 0 holds base 16'hC0E0 and mask 16'hFFF0 and is enabled, and all other entries are disabled. A `cfg_we` pulse loads `cfg_base`, `cfg_mask` and `cfg_en` into entry `cfg_sel`.
- R9: `bus_req` stays high with a stable address from the start of a slow access until `bus_ack`, and drops in the following cycle. `cpu_ready` is low while the request is outstanding.
- R10: `hit_cnt` counts read hits, `miss_cnt` counts non-excluded read misses, and `slow_cnt` counts completed bus accesses.
- R11: With `cpu_req` low, no bus request is raised and no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Core presents an access, held until `cpu_ready` |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | ADDR_W | Access address |
| cpu_wdata | input | DATA_W | Write byte |
| cpu_rdata | output | DATA_W | Read byte, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access completes at this clock edge |
| busy | output | 1 | Tag sweep in progress |
| cfg_we | input | 1 | Load one exclusion entry |
| cfg_sel | input | SEL_W | Exclusion entry to load |
| cfg_base | input | ADDR_W | Window base |
| cfg_mask | input | ADDR_W | Window mask |
| cfg_en | input | 1 | Window enable |
| bus_req | output | 1 | Slow-bus request |
| bus_we | output | 1 | Slow-bus write |
| bus_addr | output | ADDR_W | Slow-bus address |
| bus_wdata | output | DATA_W | Slow-bus write byte |
| bus_rdata | input | DATA_W | Slow-bus read byte, valid with `bus_ack` |
| bus_ack | input | 1 | Slow-bus completion, one cycle |
| hit_cnt | output | CNT_W | Read hit count |
| miss_cnt | output | CNT_W | Read miss count |
| slow_cnt | output | CNT_W | Completed bus access count |

## Verification
The hardest state to reach from the ports is an index whose entry has been filled by one tag, then replaced under another tag, then touched through an excluded window that shares its low bits. That is the state in which a stale byte would leak out.

The stimulus draws addresses from a narrow pool:
- four upper-bit values;
- sixteen indices around the disk window;
- one of the four tags is inside the default window, and another is inside a run-time programmed window.

Aliasing, excluded writes and refills therefore collide on the same entries thousands of times. A bench memory model and a bench tag model predict the data, the bus use and the cycle count of every access.

// File: rtl/accel_pkg.sv
package accel_pkg;

   typedef enum logic [1:0] {
      ST_SWEEP = 2'd0,
      ST_IDLE  = 2'd1,
      ST_SLOW  = 2'd2
   } ctl_state_t;

   localparam int CNT_HIT  = 0;
   localparam int CNT_MISS = 1;
   localparam int CNT_SLOW = 2;
   localparam int CNT_NUM  = 3;

endpackage

// File: rtl/excl_table.sv
module excl_table #(
   parameter int          ADDR_W    = 16,
   parameter int          NUM_EXCL  = 4,
   parameter int          SEL_W     = 2,
   parameter logic [15:0] DFLT_BASE = 16'hC0E0,
   parameter logic [15:0] DFLT_MASK = 16'hFFF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W-1:0] cfg_mask,
   input  logic              cfg_en,
   input  logic [ADDR_W-1:0] addr,
   output logic              excluded
);

   logic [NUM_EXCL-1:0] match;

   for (genvar i = 0; i < NUM_EXCL; i++) begin : g_win
      logic [ADDR_W-1:0] base_q;
      logic [ADDR_W-1:0] mask_q;
      logic              en_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q <= (i == 0) ? ADDR_W'(DFLT_BASE) : '0;
            mask_q <= (i == 0) ? ADDR_W'(DFLT_MASK) : '0;
            en_q   <= (i == 0);
         end else if (cfg_we && (cfg_sel == SEL_W'(i))) begin
            base_q <= cfg_base;
            mask_q <= cfg_mask;
            en_q   <= cfg_en;
         end
      end

      assign match[i] = en_q && ((addr & mask_q) == base_q);
   end

   assign excluded = |match;

endmodule

// File: rtl/cache_store.sv
module cache_store #(
   parameter int IDX_W  = 13,
   parameter int TAG_W  = 3,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [TAG_W-1:0]  rd_tag,
   output logic              rd_valid,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic              clr_en,
   input  logic [IDX_W-1:0]  clr_idx
);

   localparam int DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] data_mem [DEPTH];
   logic [TAG_W-1:0]  tag_mem  [DEPTH];
   logic              vld_mem  [DEPTH];

   always_ff @(posedge clk) begin
      if (clr_en) begin
         vld_mem[clr_idx] <= 1'b0;
      end else if (wr_en) begin
         data_mem[wr_idx] <= wr_data;
         tag_mem[wr_idx]  <= wr_tag;
         vld_mem[wr_idx]  <= 1'b1;
      end
   end

   assign rd_data  = data_mem[rd_idx];
   assign rd_tag   = tag_mem[rd_idx];
   assign rd_valid = vld_mem[rd_idx];

endmodule

// File: rtl/perf_counters.sv
module perf_counters #(
   parameter int NUM   = 3,
   parameter int CNT_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM-1:0]       inc,
   output logic [NUM*CNT_W-1:0] cnt
);

   for (genvar i = 0; i < NUM; i++) begin : g_cnt
      logic [CNT_W-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q <= '0;
         else if (inc[i]) q <= q + 1'b1;
      end

      assign cnt[i*CNT_W +: CNT_W] = q;
   end

endmodule

// File: rtl/accel_cache_ctrl.sv
module accel_cache_ctrl
   import accel_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter int          IDX_W     = 13,
   parameter int          NUM_EXCL  = 4,
   parameter int          CNT_W     = 16,
   parameter logic [15:0] DFLT_BASE = 16'hC0E0,
   parameter logic [15:0] DFLT_MASK = 16'hFFF0,
   localparam int         SEL_W     = (NUM_EXCL > 1) ? $clog2(NUM_EXCL) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic              busy,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W-1:0] cfg_mask,
   input  logic              cfg_en,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ack,
   output logic [CNT_W-1:0]  hit_cnt,
   output logic [CNT_W-1:0]  miss_cnt,
   output logic [CNT_W-1:0]  slow_cnt
);

   localparam int TAG_W    = ADDR_W - IDX_W;
   localparam int LAST_IDX = (1 << IDX_W) - 1;

   // elaboration-time parameter checks
   if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_idx
      $error("IDX_W must lie between 1 and ADDR_W-1");
   end
   if (NUM_EXCL < 1) begin : g_bad_excl
      $error("NUM_EXCL must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   ctl_state_t        st_q;
   logic [IDX_W-1:0]  sweep_q;
   logic [ADDR_W-1:0] l_addr_q;
   logic [DATA_W-1:0] l_wdata_q;
   logic              l_we_q;
   logic              l_excl_q;

   logic              excl_now;
   logic [DATA_W-1:0] c_data;
   logic [TAG_W-1:0]  c_tag;
   logic              c_valid;
   logic              hit_now;
   logic              done_slow;
   logic              fill_en;
   logic [CNT_NUM-1:0]       cnt_inc;
   logic [CNT_NUM*CNT_W-1:0] cnt_bus;

   excl_table #(
      .ADDR_W   (ADDR_W),
      .NUM_EXCL (NUM_EXCL),
      .SEL_W    (SEL_W),
      .DFLT_BASE(DFLT_BASE),
      .DFLT_MASK(DFLT_MASK)
   ) u_excl (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_we  (cfg_we),
      .cfg_sel (cfg_sel),
      .cfg_base(cfg_base),
      .cfg_mask(cfg_mask),
      .cfg_en  (cfg_en),
      .addr    (cpu_addr),
      .excluded(excl_now)
   );

   assign done_slow = (st_q == ST_SLOW) && bus_ack;
   assign fill_en   = done_slow && !l_excl_q;

   cache_store #(
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .DATA_W(DATA_W)
   ) u_store (
      .clk     (clk),
      .rd_idx  (cpu_addr[IDX_W-1:0]),
      .rd_data (c_data),
      .rd_tag  (c_tag),
      .rd_valid(c_valid),
      .wr_en   (fill_en),
      .wr_idx  (l_addr_q[IDX_W-1:0]),
      .wr_data (l_we_q ? l_wdata_q : bus_rdata),
      .wr_tag  (l_addr_q[ADDR_W-1:IDX_W]),
      .clr_en  (st_q == ST_SWEEP),
      .clr_idx (sweep_q)
   );

   // fast path: a read outside every window whose tag matches
   assign hit_now = (st_q == ST_IDLE) && cpu_req && !cpu_we && !excl_now &&
                    c_valid && (c_tag == cpu_addr[ADDR_W-1:IDX_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_SWEEP;
         sweep_q   <= '0;
         l_addr_q  <= '0;
         l_wdata_q <= '0;
         l_we_q    <= 1'b0;
         l_excl_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_SWEEP: begin
               sweep_q <= sweep_q + 1'b1;
               if (sweep_q == IDX_W'(LAST_IDX)) st_q <= ST_IDLE;
            end
            ST_IDLE: begin
               if (cpu_req && !hit_now) begin
                  st_q      <= ST_SLOW;
                  l_addr_q  <= cpu_addr;
                  l_wdata_q <= cpu_wdata;
                  l_we_q    <= cpu_we;
                  l_excl_q  <= excl_now;
               end
            end
            ST_SLOW: begin
               if (bus_ack) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign bus_req   = (st_q == ST_SLOW);
   assign bus_we    = l_we_q;
   assign bus_addr  = l_addr_q;
   assign bus_wdata = l_wdata_q;

   assign cpu_ready = hit_now || done_slow;
   assign cpu_rdata = done_slow ? bus_rdata : c_data;
   assign busy      = (st_q == ST_SWEEP);

   always_comb begin
      cnt_inc           = '0;
      cnt_inc[CNT_HIT]  = hit_now;
      cnt_inc[CNT_MISS] = done_slow && !l_we_q && !l_excl_q;
      cnt_inc[CNT_SLOW] = done_slow;
   end

   perf_counters #(
      .NUM  (CNT_NUM),
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (cnt_inc),
      .cnt  (cnt_bus)
   );

   assign hit_cnt  = cnt_bus[CNT_HIT*CNT_W  +: CNT_W];
   assign miss_cnt = cnt_bus[CNT_MISS*CNT_W +: CNT_W];
   assign slow_cnt = cnt_bus[CNT_SLOW*CNT_W +: CNT_W];

endmodule

// File: rtl/accel_cache_ctrl_chk.sv
module accel_cache_ctrl_chk #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic              cpu_ready,
   input logic              busy,
   input logic              bus_req,
   input logic              bus_ack,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [CNT_W-1:0]  hit_cnt,
   input logic [CNT_W-1:0]  slow_cnt
);

   a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr));

   a_r9_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack |=> !bus_req);

   a_r9_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |-> !cpu_ready);

   a_r2_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cpu_ready && !bus_req);

   a_r5_write_slow: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_we && cpu_ready |-> bus_ack);

   a_r10_hit_count: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready && !bus_ack |=> hit_cnt == CNT_W'($past(hit_cnt) + 1'b1));

   a_r10_slow_count: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack |=> slow_cnt == CNT_W'($past(slow_cnt) + 1'b1));

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req && !bus_req |=> !bus_req);

endmodule

bind accel_cache_ctrl accel_cache_ctrl_chk #(
   .ADDR_W(ADDR_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_req  (cpu_req),
   .cpu_we   (cpu_we),
   .cpu_ready(cpu_ready),
   .busy     (busy),
   .bus_req  (bus_req),
   .bus_ack  (bus_ack),
   .bus_addr (bus_addr),
   .hit_cnt  (hit_cnt),
   .slow_cnt (slow_cnt)
);

// File: tb/accel_cache_ctrl_tb_top.sv
module accel_cache_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic        cpu_ready, busy;
   logic        cfg_we = 1'b0, cfg_en = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [15:0] cfg_base = '0, cfg_mask = '0;
   logic        bus_req, bus_we;
   logic [15:0] bus_addr;
   logic [7:0]  bus_wdata;
   logic [7:0]  bus_rdata = '0;
   logic        bus_ack = 1'b0;
   logic [15:0] hit_cnt, miss_cnt, slow_cnt;

   always #2 clk = ~clk;

   accel_cache_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .busy(busy),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
      .cfg_mask(cfg_mask), .cfg_en(cfg_en),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
      .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .slow_cnt(slow_cnt)
   );

   int n_checks = 0, n_err = 0;
   int bus_cnt = 0;
   int t_hit = 0, t_miss = 0, t_slow = 0;
   bit reported = 1'b0;

   logic [7:0]  mem  [int];
   logic [2:0]  mtag [int];
   logic [15:0] b_base [4];
   logic [15:0] b_mask [4];
   bit          b_en   [4];

   function automatic logic [7:0] mem_rd(input logic [15:0] a);
      if (mem.exists(int'(a))) return mem[int'(a)];
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   function automatic bit excl_model(input logic [15:0] a);
      for (int i = 0; i < 4; i++)
         if (b_en[i] && ((a & b_mask[i]) == b_base[i])) return 1'b1;
      return 1'b0;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      end
      $finish;
   endtask

   // slow bus model: acknowledges on the third low phase of a request
   initial begin
      int wait_n = 0;
      forever begin
         @(negedge clk);
         if (bus_ack) begin
            bus_ack = 1'b0;
         end else if (bus_req) begin
            wait_n++;
            if (wait_n == 3) begin
               wait_n = 0;
               bus_cnt++;
               if (bus_we) begin
                  mem[int'(bus_addr)] = bus_wdata;
                  bus_rdata = 8'h00;
               end else begin
                  bus_rdata = mem_rd(bus_addr);
               end
               bus_ack = 1'b1;
            end
         end
      end
   end

   task automatic access(input bit we, input logic [15:0] a, input logic [7:0] wd,
                         output logic [7:0] rd, output int cyc, output bit used);
      int b0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      b0 = bus_cnt; cyc = 0; rd = '0;
      forever begin
         #1;
         cyc++;
         if (cpu_ready) begin
            rd = cpu_rdata;
            break;
         end
         @(negedge clk);
      end
      @(posedge clk);
      #1;
      cpu_req = 1'b0; cpu_we = 1'b0;
      used = (bus_cnt != b0);
   endtask

   task automatic do_op(input bit we, input logic [15:0] a, input logic [7:0] wd,
                        input string req);
      logic [7:0] exp_rd, rd;
      bit ex, hit, used;
      int idx, cyc;
      exp_rd = mem_rd(a);
      ex  = excl_model(a);
      idx = int'(a[12:0]);
      hit = !we && !ex && mtag.exists(idx) && (mtag[idx] == a[15:13]);
      access(we, a, wd, rd, cyc, used);
      if (!we) chk(rd == exp_rd, req, "read data", int'(rd), int'(exp_rd));
      chk(used == !hit, req, "bus used", int'(used), int'(!hit));
      if (hit) chk(cyc == 1, req, "hit cycles", cyc, 1);
      else     chk(cyc > 1, req, "slow cycles", cyc, 4);
      if (we)  chk(mem_rd(a) == wd, req, "write through", int'(mem_rd(a)), int'(wd));
      if (!ex) mtag[idx] = a[15:13];
      if (hit) t_hit++;
      if (!hit) t_slow++;
      if (!we && !ex && !hit) t_miss++;
   endtask

   task automatic set_win(input int sel, input logic [15:0] base,
                          input logic [15:0] mask, input bit en);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_base = base; cfg_mask = mask; cfg_en = en;
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
      b_base[sel] = base; b_mask[sel] = mask; b_en[sel] = en;
   endtask

   initial begin
      #(4 * 200000);
      n_checks++; n_err++;
      $display("FAIL watchdog run did not finish");
      report();
   end

   initial begin
      int n;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4; i++) begin
         b_base[i] = '0; b_mask[i] = '0; b_en[i] = 1'b0;
      end
      b_base[0] = 16'hC0E0; b_mask[0] = 16'hFFF0; b_en[0] = 1'b1;  // R8 default window

      // R1 reset state
      #9;
      chk(busy == 1'b1, "R1", "busy in reset", int'(busy), 1);
      chk(cpu_ready == 1'b0 && bus_req == 1'b0, "R1", "ready/req in reset",
          int'({cpu_ready, bus_req}), 0);
      chk(hit_cnt == 0 && miss_cnt == 0 && slow_cnt == 0, "R1", "counters in reset",
          int'(slow_cnt), 0);

      // R2 sweep length
      @(negedge clk);
      rst_n = 1'b1;
      n = 0;
      forever begin
         @(posedge clk);
         #1;
         n++;
         if (!busy || n > 20000) break;
      end
      chk(n == 8192, "R2", "sweep edges", n, 8192);

      // R11 idle: no bus activity
      repeat (6) @(posedge clk);
      #1;
      chk(bus_cnt == 0 && !bus_req, "R11", "idle bus", bus_cnt, 0);
      chk(slow_cnt == 0 && hit_cnt == 0, "R11", "idle counters", int'(slow_cnt), 0);

      // R4 miss then R3 hit
      do_op(1'b0, 16'h1234, 8'h00, "R4");
      do_op(1'b0, 16'h1234, 8'h00, "R3");
      // R5 write through, then hit with new data
      do_op(1'b1, 16'h1234, 8'hA5, "R5");
      do_op(1'b0, 16'h1234, 8'h00, "R5");
      // R6 aliasing on the same index
      do_op(1'b0, 16'h3234, 8'h00, "R6");
      do_op(1'b0, 16'h1234, 8'h00, "R6");
      do_op(1'b0, 16'h3234, 8'h00, "R6");
      // R8 default disk window always slow
      do_op(1'b0, 16'hC0E5, 8'h00, "R8");
      do_op(1'b0, 16'hC0E5, 8'h00, "R8");
      do_op(1'b1, 16'hC0E5, 8'h3C, "R7");
      do_op(1'b0, 16'hC0E5, 8'h00, "R7");
      // R7 programmed window
      set_win(1, 16'h8000, 16'hC000, 1'b1);
      do_op(1'b0, 16'h9000, 8'h00, "R7");
      do_op(1'b0, 16'h9000, 8'h00, "R7");
      do_op(1'b1, 16'hA001, 8'h77, "R7");
      do_op(1'b0, 16'hA001, 8'h00, "R7");
      // R8 disabling the default window makes its range cacheable
      set_win(0, 16'hC0E0, 16'hFFF0, 1'b0);
      do_op(1'b0, 16'hC0E5, 8'h00, "R8");
      do_op(1'b0, 16'hC0E5, 8'h00, "R8");
      set_win(0, 16'hC0E0, 16'hFFF0, 1'b1);
      do_op(1'b0, 16'hC0E5, 8'h00, "R8");

      // random mix over a narrow pool
      for (int k = 0; k < 3000; k++) begin
         logic [2:0]  tg;
         logic [15:0] a;
         int r;
         r = int'($urandom % 4);
         tg = (r == 0) ? 3'd0 : (r == 1) ? 3'd1 : (r == 2) ? 3'd4 : 3'd6;
         a = {tg, 13'h00E0 + 13'($urandom % 16)};
         if (($urandom % 4) == 0) do_op(1'b1, a, 8'($urandom), "R5");
         else                     do_op(1'b0, a, 8'h00, "R3");
      end

      // R10 counters
      #1;
      chk(int'(hit_cnt) == t_hit, "R10", "hit count", int'(hit_cnt), t_hit);
      chk(int'(miss_cnt) == t_miss, "R10", "miss count", int'(miss_cnt), t_miss);
      chk(int'(slow_cnt) == t_slow, "R10", "slow count", int'(slow_cnt), t_slow);
      chk(bus_cnt == t_slow, "R9", "bus handshakes", bus_cnt, t_slow);
      report();
   end

endmodule